// File: doc/BRIEF.md
# Protected Parallel Output Latch Controller

This block is the clocked control logic for an eight-channel low-side output driver with fault protection. Eight parallel data bits are captured into per-channel latches under a level-sensitive load control, and a level-sensitive wipe control forces every latch to the off state. Each latch drives one channel-on signal toward an external power stage. An active-low enable input gates all channels. Driving that input high also re-arms the protection logic.

Protection comes from three synchronous inputs. Each channel has its own overcurrent comparator input. An overcurrent must stay asserted for a programmable number of clock cycles before it becomes a sticky fault. That fault turns off only the affected channel and holds until the enable input goes high or the block is reset. An overtemperature input turns off every channel while it is asserted, but it leaves nothing latched. An undervoltage input acts exactly like driving the enable input high. An active-low fault flag reports any latched channel fault or an active overtemperature.

Top module: `prot_latch_ctrl`

## Requirements
- R1: While rst_ni is low, every latch is off, every channel fault is cleared, chan_on_o is all zero and flag_no is high.
- R2: At each clock edge where strobe_i is high and clear_i is low, each latch takes its data_i bit (bit n drives channel n; 1 means on). With strobe_i low, the latches keep their value.
- R3: At a clock edge where clear_i is high, every latch becomes off, whatever strobe_i and data_i are.
- R4: While oe_ni is high, chan_on_o is all zero. While oe_ni is low, each channel shows its latch value, and latch contents survive an oe_ni high period.
- R5: If oc_i[n] is high on FILT_CYC consecutive clock edges, channel n latches a fault. Its output turns off, the other channels are unaffected, and flag_no goes low.
- R6: An overcurrent pulse seen on fewer than FILT_CYC consecutive edges latches no fault. The count restarts each time oc_i[n] goes low.
- R7: A latched fault persists after oc_i[n] returns low, and clear_i does not remove it. A clock edge with oe_ni high removes it.
- R8: While ot_i is high, all outputs are off and flag_no is low. Nothing is latched, so outputs return as soon as ot_i falls.
- R9: While uv_i is high, all outputs are off, and every latched channel fault is cleared at the next clock edge.
- R10: flag_no is low exactly when some channel fault is latched or ot_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | NCH | Parallel channel data, 1 = on |
| strobe_i | input | 1 | Level load control for the latches |
| clear_i | input | 1 | Forces all latches off |
| oe_ni | input | 1 | Active-low output enable; high also re-arms faults |
| oc_i | input | NCH | Per-channel overcurrent comparator |
| ot_i | input | 1 | Overtemperature, non-latching |
| uv_i | input | 1 | Undervoltage, acts as oe_ni high |
| chan_on_o | output | NCH | Per-channel drive-on |
| flag_no | output | 1 | Active-low fault flag |

## Verification
The bench builds the block with NCH = 8 and FILT_CYC = 4. With these values the filter threshold can be probed on both sides within a few cycles: a three-cycle burst latches nothing and a four-cycle burst latches a fault. The full channel width is still exercised, so single-channel isolation shows up against neighbouring bits. The bench interleaves faults with clear, enable, overtemperature and undervoltage events, so it can check which of these events remove the sticky state and which leave it in place.

// File: rtl/prot_latch_pkg.sv
package prot_latch_pkg;
  // Condition that forces all outputs off and re-arms the channel faults.
  function automatic logic rearm_req(input logic oe_n, input logic uv);
    return oe_n | uv;
  endfunction
endpackage

// File: rtl/pol_data_latch.sv
module pol_data_latch #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] data_i,
  input  logic           strobe_i,
  input  logic           clear_i,
  output logic [NCH-1:0] latch_o
);
  logic [NCH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (clear_i)  q <= '0;
    else if (strobe_i) q <= data_i;
  end

  assign latch_o = q;
endmodule

// File: rtl/pol_oc_filter.sv
module pol_oc_filter #(
  parameter int FILT_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic rearm_i,
  output logic fault_o
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (rearm_i) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (!fault_q) begin
      if (!oc_i)              cnt_q   <= '0;
      else if (cnt_q == LAST) fault_q <= 1'b1;
      else                    cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/prot_latch_ctrl.sv
module prot_latch_ctrl #(
  parameter int NCH      = 8,
  parameter int FILT_CYC = 200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] data_i,
  input  logic           strobe_i,
  input  logic           clear_i,
  input  logic           oe_ni,
  input  logic [NCH-1:0] oc_i,
  input  logic           ot_i,
  input  logic           uv_i,
  output logic [NCH-1:0] chan_on_o,
  output logic           flag_no
);
  import prot_latch_pkg::*;

  logic [NCH-1:0] latch_q;
  logic [NCH-1:0] fault_q;
  logic           rearm;
  logic           global_off;

  assign rearm      = rearm_req(oe_ni, uv_i);
  assign global_off = rearm | ot_i;

  pol_data_latch #(.NCH(NCH)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .strobe_i (strobe_i),
    .clear_i  (clear_i),
    .latch_o  (latch_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pol_oc_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .oc_i    (oc_i[g]),
      .rearm_i (rearm),
      .fault_o (fault_q[g])
    );
  end

  assign chan_on_o = global_off ? '0 : (latch_q & ~fault_q);
  assign flag_no   = ~((|fault_q) | ot_i);
endmodule

// File: rtl/prot_latch_ctrl_chk.sv
module prot_latch_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           strobe_i,
  input logic           clear_i,
  input logic           oe_ni,
  input logic           ot_i,
  input logic           uv_i,
  input logic [NCH-1:0] latch_q,
  input logic [NCH-1:0] fault_q,
  input logic [NCH-1:0] chan_on_o,
  input logic           flag_no
);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !clear_i) |=> $stable(latch_q));

  a_r3_clear_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (latch_q == '0));

  a_r4_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (chan_on_o == '0));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !uv_i) |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

  a_r9_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || uv_i) |=> (fault_q == '0));

  a_r8_ot_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> (!flag_no && chan_on_o == '0));

  a_r5_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chan_on_o & fault_q) == '0));
endmodule

bind prot_latch_ctrl prot_latch_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strobe_i  (strobe_i),
  .clear_i   (clear_i),
  .oe_ni     (oe_ni),
  .ot_i      (ot_i),
  .uv_i      (uv_i),
  .latch_q   (latch_q),
  .fault_q   (fault_q),
  .chan_on_o (chan_on_o),
  .flag_no   (flag_no)
);

// File: tb/prot_latch_ctrl_tb.sv
module prot_latch_ctrl_tb;
  localparam int NCH  = 8;
  localparam int FILT = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] data, oc, on;
  logic           strobe, clear, oe_n, ot, uv, flag_n;
  int             checks = 0;
  int             errors = 0;
  bit             done = 0;

  always #2 clk = ~clk;

  prot_latch_ctrl #(.NCH(NCH), .FILT_CYC(FILT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .strobe_i(strobe),
    .clear_i(clear), .oe_ni(oe_n), .oc_i(oc), .ot_i(ot), .uv_i(uv),
    .chan_on_o(on), .flag_no(flag_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [NCH-1:0] exp_on, input logic exp_flag);
    checks++;
    if (on !== exp_on || flag_n !== exp_flag) begin
      errors++;
      $display("FAIL %s: on=%h flag=%b expected on=%h flag=%b", req, on, flag_n, exp_on, exp_flag);
    end
  endtask

  task automatic load(input logic [NCH-1:0] v);
    data = v; strobe = 1'b1; tick(1); strobe = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; data = '1; strobe = 1'b1; clear = 1'b0; oe_n = 1'b0;
    oc = '0; ot = 1'b0; uv = 1'b0;
    tick(3);
    chk("R1 in reset", 8'h00, 1'b1);
    strobe = 1'b0; rst_n = 1'b1; tick(1);
    chk("R1 after release", 8'h00, 1'b1);
  endtask

  task automatic t_strobe();
    load(8'hA5);
    chk("R2 load A5", 8'hA5, 1'b1);
    data = 8'h3C; tick(2);
    chk("R2 hold with strobe low", 8'hA5, 1'b1);
    load(8'h3C);
    chk("R2 load 3C", 8'h3C, 1'b1);
  endtask

  task automatic t_clear();
    data = 8'hFF; strobe = 1'b1; clear = 1'b1; tick(1);
    chk("R3 clear beats strobe", 8'h00, 1'b1);
    clear = 1'b0; strobe = 1'b0; tick(1);
    chk("R3 stays off", 8'h00, 1'b1);
  endtask

  task automatic t_oe();
    load(8'h5A);
    oe_n = 1'b1; tick(2);
    chk("R4 oe high off", 8'h00, 1'b1);
    oe_n = 1'b0; tick(1);
    chk("R4 latch restored", 8'h5A, 1'b1);
  endtask

  task automatic t_fault();
    load(8'hFF);
    oc = 8'h04; tick(FILT - 1);
    chk("R5 below threshold", 8'hFF, 1'b1);
    tick(1);
    chk("R5 fault ch2", 8'hFB, 1'b0);
    oc = '0; tick(2);
    chk("R7 sticky", 8'hFB, 1'b0);
    clear = 1'b1; tick(1); clear = 1'b0;
    chk("R7 clear keeps fault", 8'h00, 1'b0);
    load(8'hFF);
    chk("R7 reload masked", 8'hFB, 1'b0);
    oe_n = 1'b1; tick(1);
    chk("R7 oe rearm", 8'h00, 1'b1);
    oe_n = 1'b0; tick(1);
    chk("R7 recovered", 8'hFF, 1'b1);
  endtask

  task automatic t_short();
    oc = 8'h20; tick(FILT - 1);
    oc = '0; tick(1);
    oc = 8'h20; tick(FILT - 1);
    chk("R6 short bursts ignored", 8'hFF, 1'b1);
    oc = '0; tick(1);
    chk("R6 still clean", 8'hFF, 1'b1);
  endtask

  task automatic t_ot();
    ot = 1'b1; tick(1);
    chk("R8 ot off", 8'h00, 1'b0);
    ot = 1'b0; tick(1);
    chk("R8 ot released", 8'hFF, 1'b1);
    oc = 8'h80; tick(FILT); oc = '0; ot = 1'b1; tick(1);
    chk("R10 fault and ot", 8'h00, 1'b0);
    ot = 1'b0; tick(1);
    chk("R10 fault only", 8'h7F, 1'b0);
  endtask

  task automatic t_uv();
    oc = 8'h01; tick(FILT); oc = '0;
    chk("R9 two faults", 8'h7E, 1'b0);
    uv = 1'b1; tick(1);
    chk("R9 uv off and rearm", 8'h00, 1'b1);
    uv = 1'b0; tick(1);
    chk("R9 recovered", 8'hFF, 1'b1);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_strobe();
    t_clear();
    t_oe();
    t_fault();
    t_short();
    t_ot();
    t_uv();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: on=%h flag=%b expected completion", on, flag_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule